// File: doc/BRIEF.md
# Interrupt Arbitration and Entry Sequencer

This block sits beside the control path of an 8-bit accumulator processor and owns interrupt entry. It watches a non-maskable request line for falling edges and a maskable request line for a low level, and holds each in its own latch. At every opcode fetch it decides whether an interrupt is due and which one. When the core then signals that the instruction has finished, the block takes over the memory bus for a fixed run of cycles. In that run it saves the return address and the status byte on the stack, fetches the handler address, and hands the new PC, SP and status values back to the core through load strobes.

The core gives the block its current PC, SP and status byte, the fetched opcode, a fetch strobe, an end-of-instruction strobe, and a flag that marks an instruction which has just cleared the interrupt mask. While `seq_busy` is high the core stalls, and the block ignores its strobes. Memory reads are synchronous: read data returns in the cycle after the address is presented.

Top module: `int_entry_ctrl`

## Requirements
- R1: A falling edge on `nmi_n` is synchronised and held in a latch until it is accepted at an opcode fetch. The status mask does not affect it. A line held low yields exactly one entry.
- R2: When both requests are pending at a fetch, only the non-maskable one is entered. The maskable request stays latched and is entered at a later fetch once the mask allows it.
- R3: A maskable request is accepted at a fetch only when status bit 2 (interrupt mask) of `core_p` is 0.
- R4: A maskable request is not accepted at a fetch whose opcode is 0x40 (return from interrupt). It remains pending for the next fetch.
- R5: The decision is made at the fetch, and the entry begins in the cycle after the `insn_end` strobe. `seq_busy` is high for exactly 7 cycles per entry, and with no pending request no entry occurs.
- R6: Entry cycles 2 to 4 write, in order, the PC high byte to 0x0100+SP, the PC low byte to 0x0100+SP-1, and the status byte with bit 4 (break) cleared to 0x0100+SP-2. No other cycle writes.
- R7: Cycles 5 and 6 read the vector low and high bytes, little-endian: 0xFFFA/0xFFFB for the non-maskable request and 0xFFFE/0xFFFF for the maskable one. In cycle 7 `pc_ld` presents {high, low}.
- R8: In cycle 7 `sp_ld` presents SP-3. `p_ld` presents the saved status with bit 2 set and bit 3 (decimal) cleared, and every other bit unchanged.
- R9: The non-maskable latch clears when the request is accepted. The maskable latch clears only when its entry starts, so a maskable pulse that is released before it is taken is still entered, and it is entered only once.
- R10: When an instruction ends with `insn_unmask` high and a maskable request is pending, the maskable entry begins right after that instruction, even though the mask was set at its fetch.
- R11: After reset the block is idle: `seq_busy`, `mem_we` and all load strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_n | input | 1 | Non-maskable request, falling-edge active, asynchronous |
| irq_n | input | 1 | Maskable request, active-low level |
| op_fetch | input | 1 | Core fetches an opcode this cycle |
| op_code | input | 8 | Opcode being fetched |
| insn_end | input | 1 | Current instruction completes this cycle |
| insn_unmask | input | 1 | With insn_end: the ending instruction cleared a set mask |
| core_pc | input | 16 | Core PC (return address at insn_end) |
| core_sp | input | 8 | Core stack pointer |
| core_p | input | 8 | Core status byte |
| seq_busy | output | 1 | Entry sequence owns the bus; core stalls |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, one cycle after address |
| pc_ld | output | 1 | Load pc_nxt into the core PC |
| pc_nxt | output | 16 | Handler address |
| sp_ld | output | 1 | Load sp_nxt into the core SP |
| sp_nxt | output | 8 | Stack pointer after the three pushes |
| p_ld | output | 1 | Load p_nxt into the core status |
| p_nxt | output | 8 | Status on handler entry |

## Verification
Two functions can fall on the same fetch: arbitration between the two request sources, and deferral of the maskable one. The bench holds the maskable line low, pulses the non-maskable line, and then fetches once. It expects the non-maskable vector, then a second maskable entry after the mask is cleared. A second collision happens at the end of an unmasking instruction, where a maskable request refused at fetch must still start an entry. Both cases are judged against a behavioural model that predicts bus address, data, write enable and load strobes on every clock.

// File: rtl/int_entry_pkg.sv
package int_entry_pkg;
   localparam int BIT_MASK  = 2;
   localparam int BIT_DEC   = 3;
   localparam int BIT_BRK   = 4;
   localparam int ENTRY_CYC = 7;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_NMI  = 2'd1,
      SRC_IRQ  = 2'd2
   } int_src_e;
endpackage

// File: rtl/int_edge_sync.sv
module int_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_n,
   output logic fall
);
   logic [STAGES:0] chain;

   initial begin
      stages_chk: assert (STAGES >= 2) else $error("STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-1:0], sig_n};
   end

   assign fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/int_arbiter.sv
module int_arbiter
   import int_entry_pkg::*;
#(
   parameter int                DATA_W  = 8,
   parameter logic [DATA_W-1:0] RETI_OP = 8'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi_fall,
   input  logic              irq_lvl,
   input  logic              fetch,
   input  logic [DATA_W-1:0] opcode,
   input  logic [DATA_W-1:0] status,
   input  logic              insn_end,
   input  logic              unmask,
   input  logic              busy,
   output logic              start,
   output int_src_e          src_sel
);
   logic     nmi_pend, irq_pend;
   int_src_e armed;
   logic     fetch_ok, end_ok, irq_ok, arm_nmi, arm_irq, take_irq;

   assign fetch_ok = fetch & ~busy;
   assign end_ok   = insn_end & ~busy;
   assign irq_ok   = irq_pend & ~status[BIT_MASK] & (opcode != RETI_OP);
   assign arm_nmi  = fetch_ok & nmi_pend;
   assign arm_irq  = fetch_ok & ~nmi_pend & irq_ok;

   always_comb begin
      src_sel = armed;
      if (armed == SRC_NONE && unmask && irq_pend) src_sel = SRC_IRQ;
   end

   assign start    = end_ok & (src_sel != SRC_NONE);
   assign take_irq = start & (src_sel == SRC_IRQ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_pend <= 1'b0;
         irq_pend <= 1'b0;
         armed    <= SRC_NONE;
      end else begin
         nmi_pend <= (nmi_pend & ~arm_nmi) | nmi_fall;
         irq_pend <= take_irq ? 1'b0 : (irq_pend | irq_lvl);
         if (fetch_ok)
            armed <= arm_nmi ? SRC_NMI : (arm_irq ? SRC_IRQ : SRC_NONE);
         else if (end_ok)
            armed <= SRC_NONE;
      end
   end

   // R9
   nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_pend && !fetch_ok |=> nmi_pend);
   // R9
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pend && !take_irq |=> irq_pend);
   // R3
   mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_ok && status[BIT_MASK] && !nmi_pend |=> armed == SRC_NONE);
   // R4
   reti_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_ok && opcode == RETI_OP && !nmi_pend |=> armed == SRC_NONE);
   // R2
   nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_ok && nmi_pend |=> armed == SRC_NMI);
endmodule

// File: rtl/int_entry_seq.sv
module int_entry_seq
   import int_entry_pkg::*;
#(
   parameter int                ADDR_W     = 16,
   parameter int                DATA_W     = 8,
   parameter logic [ADDR_W-1:0] STACK_BASE = 16'h0100,
   parameter logic [ADDR_W-1:0] NMI_VEC    = 16'hFFFA,
   parameter logic [ADDR_W-1:0] IRQ_VEC    = 16'hFFFE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  int_src_e          src,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [DATA_W-1:0] sp_in,
   input  logic [DATA_W-1:0] p_in,
   input  logic [DATA_W-1:0] rdata,
   output logic              busy,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata,
   output logic              we,
   output logic              pc_ld,
   output logic [ADDR_W-1:0] pc_nxt,
   output logic              sp_ld,
   output logic [DATA_W-1:0] sp_nxt,
   output logic              p_ld,
   output logic [DATA_W-1:0] p_nxt
);
   localparam int CNT_W = $clog2(ENTRY_CYC);
   localparam logic [CNT_W-1:0] K_PCH  = CNT_W'(1);
   localparam logic [CNT_W-1:0] K_PCL  = CNT_W'(2);
   localparam logic [CNT_W-1:0] K_PSW  = CNT_W'(3);
   localparam logic [CNT_W-1:0] K_VLO  = CNT_W'(4);
   localparam logic [CNT_W-1:0] K_VHI  = CNT_W'(5);
   localparam logic [CNT_W-1:0] K_LAST = CNT_W'(ENTRY_CYC - 1);

   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] pc_q, vec_q;
   logic [DATA_W-1:0] sp_q, p_q, vlo_q;

   function automatic logic [ADDR_W-1:0] stk(input logic [DATA_W-1:0] sp);
      return STACK_BASE | ADDR_W'(sp);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt   <= '0;
         pc_q  <= '0;
         vec_q <= '0;
         sp_q  <= '0;
         p_q   <= '0;
         vlo_q <= '0;
      end else if (!busy) begin
         if (start) begin
            busy  <= 1'b1;
            cnt   <= '0;
            pc_q  <= pc_in;
            sp_q  <= sp_in;
            p_q   <= p_in;
            vec_q <= (src == SRC_NMI) ? NMI_VEC : IRQ_VEC;
         end
      end else begin
         if (cnt == K_VHI) vlo_q <= rdata;
         if (cnt == K_LAST) busy <= 1'b0;
         else               cnt  <= cnt + CNT_W'(1);
      end
   end

   always_comb begin
      addr  = '0;
      wdata = '0;
      we    = 1'b0;
      pc_ld = 1'b0;
      sp_ld = 1'b0;
      p_ld  = 1'b0;
      if (busy) begin
         case (cnt)
            K_PCH: begin
               addr = stk(sp_q); wdata = pc_q[ADDR_W-1:DATA_W]; we = 1'b1;
            end
            K_PCL: begin
               addr = stk(sp_q - DATA_W'(1)); wdata = pc_q[DATA_W-1:0]; we = 1'b1;
            end
            K_PSW: begin
               addr = stk(sp_q - DATA_W'(2)); wdata = p_q; wdata[BIT_BRK] = 1'b0; we = 1'b1;
            end
            K_VLO: addr = vec_q;
            K_VHI: addr = vec_q + ADDR_W'(1);
            K_LAST: begin
               addr  = vec_q + ADDR_W'(1);
               pc_ld = 1'b1;
               sp_ld = 1'b1;
               p_ld  = 1'b1;
            end
            default: addr = pc_q;
         endcase
      end
   end

   assign pc_nxt = {rdata, vlo_q};
   assign sp_nxt = sp_q - DATA_W'(3);
   always_comb begin
      p_nxt           = p_q;
      p_nxt[BIT_MASK] = 1'b1;
      p_nxt[BIT_DEC]  = 1'b0;
   end

   // R5
   busy_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cnt != K_LAST |=> busy);
   // R5
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_ld |=> !busy);
   // R6
   stack_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> addr[ADDR_W-1:DATA_W] == STACK_BASE[ADDR_W-1:DATA_W]);
   // R7
   vec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cnt == K_VLO |=> addr == vec_q + ADDR_W'(1) && !we);
   // R8
   load_trio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_ld |-> sp_ld && p_ld && p_nxt[BIT_MASK] && !p_nxt[BIT_DEC]);
endmodule

// File: rtl/int_entry_ctrl.sv
module int_entry_ctrl
   import int_entry_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter int                DATA_W      = 8,
   parameter int                NMI_STAGES  = 2,
   parameter int                IRQ_STAGES  = 0,
   parameter logic [DATA_W-1:0] RETI_OP     = 8'h40,
   parameter logic [ADDR_W-1:0] STACK_BASE  = 16'h0100,
   parameter logic [ADDR_W-1:0] NMI_VEC     = 16'hFFFA,
   parameter logic [ADDR_W-1:0] IRQ_VEC     = 16'hFFFE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi_n,
   input  logic              irq_n,
   input  logic              op_fetch,
   input  logic [DATA_W-1:0] op_code,
   input  logic              insn_end,
   input  logic              insn_unmask,
   input  logic [ADDR_W-1:0] core_pc,
   input  logic [DATA_W-1:0] core_sp,
   input  logic [DATA_W-1:0] core_p,
   output logic              seq_busy,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              pc_ld,
   output logic [ADDR_W-1:0] pc_nxt,
   output logic              sp_ld,
   output logic [DATA_W-1:0] sp_nxt,
   output logic              p_ld,
   output logic [DATA_W-1:0] p_nxt
);
   logic     nmi_fall, irq_lvl, start;
   int_src_e src_sel;

   initial begin
      width_chk: assert (ADDR_W == 2 * DATA_W) else $error("PC must be two data words");
      flag_chk:  assert (DATA_W > BIT_BRK) else $error("status too narrow for flag bits");
   end

   int_edge_sync #(.STAGES(NMI_STAGES)) u_nmi_sync (
      .clk(clk), .rst_n(rst_n), .sig_n(nmi_n), .fall(nmi_fall)
   );

   generate
      if (IRQ_STAGES == 0) begin : g_irq_direct
         assign irq_lvl = ~irq_n;
      end else begin : g_irq_sync
         logic [IRQ_STAGES-1:0] irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= '0;
            else begin
               irq_q[0] <= ~irq_n;
               for (int i = 1; i < IRQ_STAGES; i++) irq_q[i] <= irq_q[i-1];
            end
         end
         assign irq_lvl = irq_q[IRQ_STAGES-1];
      end
   endgenerate

   int_arbiter #(.DATA_W(DATA_W), .RETI_OP(RETI_OP)) u_arb (
      .clk(clk), .rst_n(rst_n), .nmi_fall(nmi_fall), .irq_lvl(irq_lvl),
      .fetch(op_fetch), .opcode(op_code), .status(core_p),
      .insn_end(insn_end), .unmask(insn_unmask), .busy(seq_busy),
      .start(start), .src_sel(src_sel)
   );

   int_entry_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STACK_BASE(STACK_BASE),
      .NMI_VEC(NMI_VEC), .IRQ_VEC(IRQ_VEC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .src(src_sel),
      .pc_in(core_pc), .sp_in(core_sp), .p_in(core_p), .rdata(mem_rdata),
      .busy(seq_busy), .addr(mem_addr), .wdata(mem_wdata), .we(mem_we),
      .pc_ld(pc_ld), .pc_nxt(pc_nxt), .sp_ld(sp_ld), .sp_nxt(sp_nxt),
      .p_ld(p_ld), .p_nxt(p_nxt)
   );

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_busy |-> !mem_we && !pc_ld && !sp_ld && !p_ld);
endmodule

// File: tb/test_int_entry_ctrl.sv
module test_int_entry_ctrl;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        nmi_n = 1'b1, irq_n = 1'b1;
   logic        op_fetch = 1'b0, insn_end = 1'b0, insn_unmask = 1'b0;
   logic [7:0]  op_code = 8'hEA;
   logic [15:0] core_pc = 16'h8000;
   logic [7:0]  core_sp = 8'hFD, core_p = 8'h31;
   logic        seq_busy, mem_we, pc_ld, sp_ld, p_ld;
   logic [15:0] mem_addr, pc_nxt;
   logic [7:0]  mem_wdata, sp_nxt, p_nxt;
   logic [7:0]  mem_rdata = 8'h00;

   int n_chk = 0, n_err = 0, cyc = 0, entries = 0, bcount = 0, wr_n = 0;
   logic [15:0] last_vec = 16'h0;
   logic [15:0] wa [3];
   logic [7:0]  wd [3];

   always #5 clk = ~clk;

   int_entry_ctrl i_int_entry_ctrl (
      .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .irq_n(irq_n),
      .op_fetch(op_fetch), .op_code(op_code), .insn_end(insn_end),
      .insn_unmask(insn_unmask), .core_pc(core_pc), .core_sp(core_sp),
      .core_p(core_p), .seq_busy(seq_busy), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
      .pc_ld(pc_ld), .pc_nxt(pc_nxt), .sp_ld(sp_ld), .sp_nxt(sp_nxt),
      .p_ld(p_ld), .p_nxt(p_nxt)
   );

   function automatic logic [7:0] mem_byte(input logic [15:0] a);
      case (a)
         16'hFFFA: return 8'h34;
         16'hFFFB: return 8'h92;
         16'hFFFE: return 8'hC7;
         16'hFFFF: return 8'h5E;
         default:  return a[7:0] ^ a[15:8] ^ 8'hA5;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory and core register file
   always @(posedge clk) begin
      mem_rdata <= mem_byte(mem_addr);
      if (pc_ld) begin core_pc <= pc_nxt; entries <= entries + 1; last_vec <= pc_nxt; end
      if (sp_ld) core_sp <= sp_nxt;
      if (p_ld)  core_p  <= p_nxt;
      if (mem_we && wr_n < 3) begin wa[wr_n] <= mem_addr; wd[wr_n] <= mem_wdata; wr_n <= wr_n + 1; end
   end

   // behavioural reference model
   bit m_s1, m_s2, m_s3, m_nmi, m_irq;
   int m_arm, m_seq, m_kind;
   logic [15:0] m_pc;
   logic [7:0]  m_sp, m_p;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 1; m_s2 = 1; m_s3 = 1; m_nmi = 0; m_irq = 0;
         m_arm = 0; m_seq = -1; m_kind = 0;
      end else begin
         bit fall, f_ok, e_ok, st, n_nmi, n_irq;
         int sel, n_arm;
         fall = m_s3 && !m_s2;
         f_ok = op_fetch && m_seq < 0;
         e_ok = insn_end && m_seq < 0;
         sel = m_arm;
         if (sel == 0 && insn_unmask && m_irq) sel = 2;
         st = e_ok && sel != 0;
         n_nmi = m_nmi; n_irq = m_irq; n_arm = m_arm;
         if (f_ok) begin
            if (m_nmi) begin n_arm = 1; n_nmi = 0; end
            else if (m_irq && !core_p[2] && op_code != 8'h40) n_arm = 2;
            else n_arm = 0;
         end else if (e_ok) n_arm = 0;
         if (fall) n_nmi = 1;
         if (st && sel == 2) n_irq = 0;
         else if (!irq_n) n_irq = 1;
         if (st) begin
            m_seq = 0; m_kind = sel; m_pc = core_pc; m_sp = core_sp; m_p = core_p;
         end else if (m_seq >= 0) m_seq = (m_seq == 6) ? -1 : m_seq + 1;
         m_nmi = n_nmi; m_irq = n_irq; m_arm = n_arm;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = nmi_n;
      end
   end

   // every-clock comparison
   always @(negedge clk) begin
      if (rst_n) begin
         logic [15:0] vec, ea;
         logic [7:0]  ed;
         bit ewe;
         vec = (m_kind == 1) ? 16'hFFFA : 16'hFFFE;
         ea = 16'h0; ed = 8'h0; ewe = 0;
         case (m_seq)
            0: ea = m_pc;
            1: begin ea = 16'h0100 | {8'h0, m_sp};         ed = m_pc[15:8]; ewe = 1; end
            2: begin ea = 16'h0100 | {8'h0, m_sp - 8'd1};  ed = m_pc[7:0];  ewe = 1; end
            3: begin ea = 16'h0100 | {8'h0, m_sp - 8'd2};  ed = m_p & 8'hEF; ewe = 1; end
            4: ea = vec;
            5, 6: ea = vec + 16'd1;
            default: ;
         endcase
         chk(seq_busy == (m_seq >= 0), "R5 busy", seq_busy, m_seq >= 0);
         chk(mem_we == ewe, "R6 we", mem_we, ewe);
         chk(mem_addr == ea, (m_seq >= 4) ? "R7 addr" : "R6 addr", mem_addr, ea);
         chk(mem_wdata == ed, "R6 wdata", mem_wdata, ed);
         chk(pc_ld == (m_seq == 6), "R7 pc_ld", pc_ld, m_seq == 6);
         if (m_seq == 6) begin
            chk(pc_nxt == {mem_byte(vec + 16'd1), mem_byte(vec)}, "R7 vector", pc_nxt,
                {mem_byte(vec + 16'd1), mem_byte(vec)});
            chk(sp_nxt == m_sp - 8'd3, "R8 sp", sp_nxt, m_sp - 8'd3);
            chk(p_nxt == ((m_p | 8'h04) & 8'hF7), "R8 status", p_nxt, (m_p | 8'h04) & 8'hF7);
         end
         if (seq_busy) bcount++;
         if (pc_ld) begin
            chk(bcount == 7, "R5 length", bcount, 7);
            bcount = 0;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_err++;
         $display("FAIL watchdog R5 actual=%0d expected=<100000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   task automatic tick; @(negedge clk); endtask

   task automatic run_insn(input logic [7:0] op, input int len, input bit unm);
      op_fetch = 1; op_code = op; tick;
      op_fetch = 0;
      repeat (len - 2) tick;
      insn_end = 1; insn_unmask = unm; tick;
      insn_end = 0; insn_unmask = 0;
      tick;
      while (seq_busy) tick;
   endtask

   initial begin
      int e0;
      repeat (3) tick;
      // R11 reset state
      chk(seq_busy == 0, "R11 busy", seq_busy, 0);
      chk(mem_we == 0, "R11 we", mem_we, 0);
      chk(pc_ld == 0 && sp_ld == 0 && p_ld == 0, "R11 loads", {pc_ld, sp_ld, p_ld}, 0);
      rst_n = 1; tick;

      // R5 no request, no entry
      run_insn(8'hEA, 2, 0); run_insn(8'hA9, 3, 0);
      chk(entries == 0, "R5 idle", entries, 0);

      // R1 / R6 / R7 / R8 non-maskable entry
      nmi_n = 0; repeat (6) tick; nmi_n = 1; tick;
      wr_n = 0;
      run_insn(8'hA9, 3, 0);
      chk(entries == 1, "R1 entered", entries, 1);
      chk(last_vec == 16'h9234, "R7 nmi vector", last_vec, 16'h9234);
      chk(wr_n == 3, "R6 writes", wr_n, 3);
      chk(wa[0] == 16'h01FD && wd[0] == 8'h80, "R6 pch", {wa[0], wd[0]}, 24'h01FD80);
      chk(wa[1] == 16'h01FC && wd[1] == 8'h00, "R6 pcl", {wa[1], wd[1]}, 24'h01FC00);
      chk(wa[2] == 16'h01FB && wd[2] == 8'h21, "R6 status", {wa[2], wd[2]}, 24'h01FB21);
      chk(core_sp == 8'hFA, "R8 sp", core_sp, 8'hFA);
      chk(core_p == 8'h35, "R8 status", core_p, 8'h35);

      // R1 line held low over two instructions, mask set: one entry
      e0 = entries;
      nmi_n = 0; repeat (5) tick;
      run_insn(8'hEA, 2, 0); run_insn(8'hEA, 2, 0);
      nmi_n = 1; tick;
      chk(entries == e0 + 1, "R1 single edge", entries, e0 + 1);

      // R3 masked request refused
      core_p = 8'h04; irq_n = 0; e0 = entries;
      run_insn(8'hEA, 2, 0); run_insn(8'hEA, 2, 0);
      chk(entries == e0, "R3 masked", entries, e0);

      // R10 / R9 unmasking instruction with a released but latched request
      irq_n = 1; tick;
      run_insn(8'h58, 2, 1);
      chk(entries == e0 + 1, "R10 unmask entry", entries, e0 + 1);
      chk(last_vec == 16'h5EC7, "R10 irq vector", last_vec, 16'h5EC7);
      core_p = 8'h00; e0 = entries;
      run_insn(8'hEA, 2, 0);
      chk(entries == e0, "R9 cleared when taken", entries, e0);

      // R4 return opcode defers the maskable request
      irq_n = 0; tick; irq_n = 1; tick;
      run_insn(8'h40, 6, 0);
      chk(entries == e0, "R4 no entry at 0x40", entries, e0);
      run_insn(8'hEA, 2, 0);
      chk(entries == e0 + 1 && last_vec == 16'h5EC7, "R4 deferred entry", last_vec, 16'h5EC7);

      // R2 both pending at the same fetch
      core_p = 8'h00; irq_n = 0; nmi_n = 0; repeat (5) tick; nmi_n = 1; tick;
      e0 = entries;
      run_insn(8'hEA, 2, 0);
      chk(entries == e0 + 1 && last_vec == 16'h9234, "R2 nmi wins", last_vec, 16'h9234);
      irq_n = 1; core_p = 8'h00; tick;
      run_insn(8'hEA, 2, 0);
      chk(entries == e0 + 2 && last_vec == 16'h5EC7, "R2 irq kept", last_vec, 16'h5EC7);
      run_insn(8'hEA, 2, 0);
      chk(entries == e0 + 2, "R9 taken once", entries, e0 + 2);

      repeat (3) tick;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule